// File: doc/BRIEF.md
# Atomic Memory Unit

This block wraps a small single-port word memory so that several requesters can run read-modify-write operations on it without interference. Each requester presents an opcode, a word address, a data operand and a comparison value. One fixed-priority arbiter picks a single request. The unit then runs a read cycle, a compute cycle and a write cycle as one indivisible sequence, and no other request is granted until that sequence finishes. The response always carries the value the word held before the operation.

Four operations exist. A plain read returns the word. A plain write stores the operand. Atomic add stores the old value plus the operand. Compare-and-swap stores the operand only when the old value equals the comparison value, and otherwise leaves the word alone. A requester that builds a lock on compare-and-swap gets the current value back on a miss, and can use it as its next comparison value.

Top module: `atomic_mem_unit`

## Requirements
- R1: While reset is held and on the first cycle after it, `rsp_valid` is low, `req_ready` is all zero when no request is valid, and every memory word reads back as zero.
- R2: In the idle state, `req_ready` is the one-hot grant of the lowest-numbered requester whose `req_valid` is high, and it is zero when no request is valid.
- R3: After a request is accepted (valid and ready high at a clock edge), `req_ready` stays all zero for the next three cycles (read, compute, write).
- R4: `rsp_valid` is high for exactly one cycle, the cycle after the write cycle (three clock edges after the accepting edge), and `rsp_id` then carries the index of the accepted requester.
- R5: Opcode 0 (read) returns the stored word in `rsp_data`, sets `rsp_ok`, and leaves memory unchanged.
- R6: Opcode 1 (write) stores `req_data` at the address, returns the previous word, and sets `rsp_ok`.
- R7: Opcode 2 (add) stores the old word plus `req_data`, modulo 2^DW, returns the old word, and sets `rsp_ok`.
- R8: Opcode 3 (compare-and-swap) with the old word equal to `req_cmp` stores `req_data`, returns the old word, and sets `rsp_ok`.
- R9: Opcode 3 with the old word not equal to `req_cmp` leaves memory unchanged, returns the current word, and clears `rsp_ok`.
- R10: Atomic adds that several requesters issue at the same time to one address are never lost: the final word equals the sum of all increments.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset; also clears the memory |
| req_valid | input | NREQ | One request-valid bit per requester |
| req_ready | output | NREQ | One-hot grant; a request is taken when its valid and ready are both high |
| req_op | input | 2*NREQ | Opcode per requester, 2 bits each: 0 read, 1 write, 2 add, 3 compare-and-swap |
| req_addr | input | NREQ*AW | Word address per requester |
| req_data | input | NREQ*DW | Write value, increment, or swap value per requester |
| req_cmp | input | NREQ*DW | Expected value used by compare-and-swap |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_id | output | IW | Index of the requester being answered |
| rsp_data | output | DW | Word value before the operation |
| rsp_ok | output | 1 | Low only when a compare-and-swap missed |

## Verification
The assertions assume that every requester holds its valid high, with its fields stable, until it is granted. They also assume that opcodes above 3 cannot occur, since the field is two bits wide. The bench drives each requester from its own queue. It raises a request at a falling edge, keeps it untouched until the model sees it accepted, and only then lowers it or presents the next one. The priority, atomicity and lock-contention checks therefore see realistic held requests rather than single-cycle pulses.

// File: rtl/atomic_mem_unit.sv
module atomic_mem_unit #(
  parameter int NREQ = 3,
  parameter int AW   = 4,
  parameter int DW   = 16,
  localparam int IW  = (NREQ > 1) ? $clog2(NREQ) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NREQ-1:0]   req_valid,
  output logic [NREQ-1:0]   req_ready,
  input  logic [2*NREQ-1:0] req_op,
  input  logic [NREQ*AW-1:0] req_addr,
  input  logic [NREQ*DW-1:0] req_data,
  input  logic [NREQ*DW-1:0] req_cmp,
  output logic              rsp_valid,
  output logic [IW-1:0]     rsp_id,
  output logic [DW-1:0]     rsp_data,
  output logic              rsp_ok
);

  localparam int DEPTH = 1 << AW;
  localparam logic [1:0] OP_RD  = 2'd0;
  localparam logic [1:0] OP_WR  = 2'd1;
  localparam logic [1:0] OP_ADD = 2'd2;
  localparam logic [1:0] OP_CAS = 2'd3;

  typedef enum logic [1:0] {S_IDLE, S_RD, S_CMP, S_WR} st_t;
  st_t st;

  logic [DW-1:0]   mem [DEPTH];
  logic [NREQ-1:0] gnt;
  logic [IW-1:0]   gid;
  logic            take, wen;
  logic [1:0]      op_q;
  logic [AW-1:0]   addr_q;
  logic [DW-1:0]   data_q, cmp_q, old_q, new_q;
  logic            ok_q;
  logic [IW-1:0]   id_q;

  assign gnt = req_valid & (~req_valid + 1'b1);

  always_comb begin
    gid = '0;
    for (int i = NREQ - 1; i >= 0; i--)
      if (gnt[i]) gid = IW'(i);
  end

  assign req_ready = (st == S_IDLE) ? gnt : '0;
  assign take      = |req_ready;
  assign wen       = ok_q && (op_q != OP_RD);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      rsp_valid <= 1'b0;
      rsp_id    <= '0;
      rsp_data  <= '0;
      rsp_ok    <= 1'b0;
      op_q      <= OP_RD;
      addr_q    <= '0;
      data_q    <= '0;
      cmp_q     <= '0;
      old_q     <= '0;
      new_q     <= '0;
      ok_q      <= 1'b0;
      id_q      <= '0;
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else begin
      rsp_valid <= 1'b0;
      case (st)
        S_IDLE: if (take) begin
          op_q   <= req_op[int'(gid)*2 +: 2];
          addr_q <= req_addr[int'(gid)*AW +: AW];
          data_q <= req_data[int'(gid)*DW +: DW];
          cmp_q  <= req_cmp[int'(gid)*DW +: DW];
          id_q   <= gid;
          st     <= S_RD;
        end
        S_RD: begin
          old_q <= mem[addr_q];
          st    <= S_CMP;
        end
        S_CMP: begin
          case (op_q)
            OP_WR:   new_q <= data_q;
            OP_ADD:  new_q <= old_q + data_q;
            OP_CAS:  new_q <= (old_q == cmp_q) ? data_q : old_q;
            default: new_q <= old_q;
          endcase
          ok_q <= (op_q != OP_CAS) || (old_q == cmp_q);
          st   <= S_WR;
        end
        default: begin
          if (wen) mem[addr_q] <= new_q;
          rsp_valid <= 1'b1;
          rsp_id    <= id_q;
          rsp_data  <= old_q;
          rsp_ok    <= ok_q;
          st        <= S_IDLE;
        end
      endcase
    end
  end

  AST_ONE_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(req_ready)); // R2
  AST_GRANT_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    (req_ready & ~req_valid) == '0); // R2
  AST_PRIO_LOWEST: assert property (@(posedge clk) disable iff (!rst_n)
    (req_ready != '0) |-> (((req_ready - 1'b1) & req_valid) == '0)); // R2
  AST_BUSY_NO_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    (st != S_IDLE) |-> (req_ready == '0)); // R3
  AST_RSP_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_WR) |=> rsp_valid); // R4
  AST_RSP_ONLY_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(st == S_WR)); // R4
  AST_ADD_STORES_SUM: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_WR && op_q == OP_ADD) |=> (mem[addr_q] == DW'(old_q + data_q))); // R7
  AST_CAS_HIT_SWAPS: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_WR && op_q == OP_CAS && old_q == cmp_q) |=> (mem[addr_q] == data_q && rsp_ok)); // R8
  AST_CAS_MISS_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_WR && op_q == OP_CAS && old_q != cmp_q) |=> (mem[addr_q] == old_q && !rsp_ok)); // R9
  AST_READ_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_WR && op_q == OP_RD) |=> (mem[addr_q] == old_q && rsp_ok)); // R5

endmodule

// File: tb/sim_atomic_mem_unit.sv
module sim_atomic_mem_unit;
  localparam int N = 3, AW = 4, DW = 16, IW = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic [N-1:0]    req_valid, req_ready;
  logic [2*N-1:0]  req_op;
  logic [N*AW-1:0] req_addr;
  logic [N*DW-1:0] req_data, req_cmp;
  logic            rsp_valid, rsp_ok;
  logic [IW-1:0]   rsp_id;
  logic [DW-1:0]   rsp_data;

  atomic_mem_unit #(.NREQ(N), .AW(AW), .DW(DW)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_addr(req_addr), .req_data(req_data), .req_cmp(req_cmp),
    .rsp_valid(rsp_valid), .rsp_id(rsp_id), .rsp_data(rsp_data), .rsp_ok(rsp_ok));

  typedef struct packed {
    logic [1:0]    op;
    logic [AW-1:0] a;
    logic [DW-1:0] d;
    logic [DW-1:0] c;
  } rq_t;

  rq_t          q [N][$];
  rq_t          cur [N];
  logic [N-1:0] cur_v;

  always_comb begin
    for (int i = 0; i < N; i++) begin
      req_valid[i]          = cur_v[i];
      req_op[i*2 +: 2]      = cur[i].op;
      req_addr[i*AW +: AW]  = cur[i].a;
      req_data[i*DW +: DW]  = cur[i].d;
      req_cmp[i*DW +: DW]   = cur[i].c;
    end
  end

  logic [DW-1:0] mm [1<<AW];
  int            cnt, acc_g, exp_id;
  bit            exp_rv, acc, exp_ok, drained;
  logic [DW-1:0] exp_d, last_rsp;
  logic [1:0]    exp_op;
  int            nchk = 0, nfail = 0;

  task automatic chk(bit good, string tag, string what, longint act, longint exp);
    nchk++;
    if (!good) begin
      nfail++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  initial for (int i = 0; i < (1 << AW); i++) mm[i] = '0;

  always @(negedge clk) begin
    if (!rst_n) begin
      cur_v = '0; cnt = 0; exp_rv = 0; acc = 0; drained = 1;
      for (int i = 0; i < N; i++) cur[i] = '0;
    end else begin
      logic [N-1:0] er;
      string tag;
      if (acc) begin cur_v[acc_g] = 1'b0; acc = 0; end
      for (int i = 0; i < N; i++)
        if (!cur_v[i] && q[i].size() > 0) begin cur[i] = q[i].pop_front(); cur_v[i] = 1'b1; end
      #1;
      er = (cnt == 0) ? (cur_v & (~cur_v + 1'b1)) : '0;
      chk(req_ready == er, (cnt == 0) ? "R2" : "R3", "req_ready", req_ready, er);
      chk(rsp_valid == exp_rv, "R4", "rsp_valid", rsp_valid, exp_rv);
      if (exp_rv && rsp_valid) begin
        case (exp_op)
          2'd0: tag = "R5";
          2'd1: tag = "R6";
          2'd2: tag = "R7";
          default: tag = exp_ok ? "R8" : "R9";
        endcase
        chk(rsp_data == exp_d, tag, "rsp_data", rsp_data, exp_d);
        chk(rsp_ok == exp_ok, tag, "rsp_ok", rsp_ok, exp_ok);
        chk(rsp_id == IW'(exp_id), "R4", "rsp_id", rsp_id, exp_id);
        last_rsp = rsp_data;
      end
      exp_rv = 0;
      if (cnt > 0) begin
        cnt--;
        if (cnt == 0) exp_rv = 1;
      end else if (cur_v != '0) begin
        int g;
        logic [DW-1:0] old;
        g = 0;
        while (!cur_v[g]) g++;
        old = mm[cur[g].a];
        exp_ok = 1;
        case (cur[g].op)
          2'd1: mm[cur[g].a] = cur[g].d;
          2'd2: mm[cur[g].a] = old + cur[g].d;
          2'd3: if (old == cur[g].c) mm[cur[g].a] = cur[g].d; else exp_ok = 0;
          default: ;
        endcase
        exp_d = old; exp_op = cur[g].op; exp_id = g;
        cnt = 3; acc = 1; acc_g = g;
      end
      drained = (cur_v == '0 || (acc && ((cur_v & ~(N'(1) << acc_g)) == '0)))
                && cnt == 0 && !exp_rv;
      for (int i = 0; i < N; i++) if (q[i].size() > 0) drained = 0;
      if (acc || cnt != 0 || exp_rv) drained = 0;
    end
  end

  task automatic push(int r, logic [1:0] op, int a, int d, int c);
    rq_t x;
    x.op = op; x.a = AW'(a); x.d = DW'(d); x.c = DW'(c);
    q[r].push_back(x);
  endtask

  task automatic drain();
    @(posedge clk); @(posedge clk);
    while (!drained) @(posedge clk);
  endtask

  initial begin
    repeat (4) @(posedge clk);
    #1;
    chk(rsp_valid == 1'b0, "R1", "rsp_valid in reset", rsp_valid, 0);
    rst_n = 1'b1;
    @(negedge clk); #1;
    chk(rsp_valid == 1'b0, "R1", "rsp_valid after reset", rsp_valid, 0);
    chk(req_ready == '0, "R1", "req_ready idle", req_ready, 0);

    // R1: memory cleared, read back on all three requesters
    push(0, 2'd0, 0, 0, 0); push(1, 2'd0, 9, 0, 0); push(2, 2'd0, 15, 0, 0);
    drain();
    chk(last_rsp == '0, "R1", "cleared word", last_rsp, 0);

    // R5 R6 R7: single requester sequence
    push(0, 2'd1, 1, 5, 0); push(0, 2'd0, 1, 0, 0);
    push(0, 2'd2, 1, 3, 0); push(0, 2'd0, 1, 0, 0);
    drain();
    chk(last_rsp == 16'd8, "R7", "add result", last_rsp, 8);

    // R7: wrap at 2^DW
    push(1, 2'd1, 4, 16'hFFFF, 0); push(1, 2'd2, 4, 2, 0); push(1, 2'd0, 4, 0, 0);
    drain();
    chk(last_rsp == 16'd1, "R7", "wrapped add", last_rsp, 1);

    // R10: concurrent adds from all requesters
    for (int k = 0; k < 10; k++)
      for (int r = 0; r < N; r++) push(r, 2'd2, 2, r + 1, 0);
    drain();
    push(2, 2'd0, 2, 0, 0);
    drain();
    chk(last_rsp == 16'd60, "R10", "sum of concurrent adds", last_rsp, 60);

    // R8 R9: lock contention, release and retry
    for (int r = N - 1; r >= 0; r--) push(r, 2'd3, 3, r + 1, 0);
    drain();
    push(0, 2'd3, 3, 0, 1);
    drain();
    push(1, 2'd3, 3, 2, 0); push(2, 2'd3, 3, 3, 0);
    drain();
    push(2, 2'd0, 3, 0, 0);
    drain();
    chk(last_rsp == 16'd2, "R8", "lock owner", last_rsp, 2);

    // mixed traffic on a small address set
    for (int k = 0; k < 300; k++)
      push(int'($urandom_range(N - 1)), 2'($urandom_range(3)), int'($urandom_range(3)),
           int'($urandom_range(7)), int'($urandom_range(7)));
    drain();

    $display("  [TB] %0d tests run, %0d failed", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog: run did not finish");
    $display("  [TB] %0d tests run, %0d failed", nchk, nfail);
    $finish;
  end
endmodule